// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell

This block lets two agents sharing a word-addressed space (left and right) notify each other. The two highest addresses serve as doorbells. A write to the top word by the left side raises the right side's flag. A write to the word just below it by the right side raises the left side's flag. Each side clears its own flag by reading the doorbell address that belongs to it. The doorbell data words are stored elsewhere; this block only tracks the two flags.

Every input is sampled on the rising clock edge, but only when that side's valid strobe is high. Each flag comes out as an active-low line that is always driven.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, both `l_irq_n` and `r_irq_n` are 1.
- R2: A left write to address AW'h...FFF (all ones) makes `r_irq_n` 0 from the next clock edge. A write is a valid cycle with `*_en`=1 and `*_wr`=1.
- R3: A right read of the all-ones address makes `r_irq_n` 1 from the next edge. A read is a valid cycle with `*_en`=1, `*_wr`=0 and `*_oe`=1.
- R4: A right write to the all-ones-minus-one address (0xFFE at 12 bits) makes `l_irq_n` 0 from the next edge.
- R5: A left read of the all-ones-minus-one address makes `l_irq_n` 1 from the next edge.
- R6: A read is ignored when `*_oe`=0 or `*_en`=0. A write is ignored when `*_en`=0. Any access with `*_vld`=0 is ignored.
- R7: If a set and a clear of the same flag land in the same cycle, the flag ends up set.
- R8: Accesses to any other address leave both flags unchanged. So do writes to a port's own doorbell and reads of the other port's doorbell.
- R9: Each flag holds its value between qualifying accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| l_vld | input | 1 | left access strobe |
| l_en | input | 1 | left enable |
| l_wr | input | 1 | left 1=write 0=read |
| l_oe | input | 1 | left output enable |
| l_addr | input | AW | left address |
| r_vld | input | 1 | right access strobe |
| r_en | input | 1 | right enable |
| r_wr | input | 1 | right 1=write 0=read |
| r_oe | input | 1 | right output enable |
| r_addr | input | AW | right address |
| l_irq_n | output | 1 | left interrupt, active low |
| r_irq_n | output | 1 | right interrupt, active low |

## Verification
The bench aims at simultaneous set and clear of one flag, where a design that gives priority to the clear would lose a message. It also covers reads with output enable low: a design that ignores `oe` would clear a flag early. Writes to a port's own doorbell and reads of the other port's doorbell are cross-checked, so swapped addresses or swapped ports show up as a wrong flag. A random stream compared every cycle against a behavioural model catches any stray change to the flags on other addresses.

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_vld,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic          r_vld,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  localparam logic [AW-1:0] R_BOX = {AW{1'b1}};
  localparam logic [AW-1:0] L_BOX = {{(AW-1){1'b1}}, 1'b0};

  logic l_flag, r_flag;

  wire l_wacc = l_vld & l_en &  l_wr;
  wire l_racc = l_vld & l_en & ~l_wr & l_oe;
  wire r_wacc = r_vld & r_en &  r_wr;
  wire r_racc = r_vld & r_en & ~r_wr & r_oe;

  wire set_r = l_wacc & (l_addr == R_BOX);
  wire clr_r = r_racc & (r_addr == R_BOX);
  wire set_l = r_wacc & (r_addr == L_BOX);
  wire clr_l = l_racc & (l_addr == L_BOX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_flag <= 1'b0;
      r_flag <= 1'b0;
    end else begin
      if (set_r)      r_flag <= 1'b1;
      else if (clr_r) r_flag <= 1'b0;
      if (set_l)      l_flag <= 1'b1;
      else if (clr_l) l_flag <= 1'b0;
    end
  end

  assign l_irq_n = ~l_flag;
  assign r_irq_n = ~r_flag;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n)); // R1
  AST_LEFT_RINGS: assert property (@(posedge clk) disable iff (!rst_n)
    (l_vld && l_en && l_wr && l_addr == R_BOX) |=> !r_irq_n); // R2
  AST_RIGHT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (r_vld && r_en && !r_wr && r_oe && r_addr == R_BOX && !(l_vld && l_en && l_wr && l_addr == R_BOX)) |=> r_irq_n); // R3
  AST_RIGHT_RINGS: assert property (@(posedge clk) disable iff (!rst_n)
    (r_vld && r_en && r_wr && r_addr == L_BOX) |=> !l_irq_n); // R4
  AST_LEFT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (l_vld && l_en && !l_wr && l_oe && l_addr == L_BOX && !(r_vld && r_en && r_wr && r_addr == L_BOX)) |=> l_irq_n); // R5
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(l_vld && l_en && l_wr) && !(r_vld && r_en && !r_wr && r_oe)) |=> $stable(r_irq_n)); // R9
  AST_L_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(r_vld && r_en && r_wr) && !(l_vld && l_en && !l_wr && l_oe)) |=> $stable(l_irq_n)); // R9
endmodule

// File: tb/tb_mbox_doorbell.sv
module tb_mbox_doorbell;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0;
  logic l_vld = 0, l_en = 0, l_wr = 0, l_oe = 0, r_vld = 0, r_en = 0, r_wr = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  int checks = 0, fails = 0;
  bit mdl_l = 0, mdl_r = 0;

  always #10 clk = ~clk;

  mbox_doorbell #(.AW(AW)) dut (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(bit lv, bit le, bit lw, bit lo, logic [AW-1:0] la,
                       bit rv, bit re, bit rw, bit ro, logic [AW-1:0] ra);
    l_vld = lv; l_en = le; l_wr = lw; l_oe = lo; l_addr = la;
    r_vld = rv; r_en = re; r_wr = rw; r_oe = ro; r_addr = ra;
    @(posedge clk);
    if (rst_n) begin
      if (rv && re && !rw && ro && ra == 12'hFFF) mdl_r = 0;
      if (lv && le && lw && la == 12'hFFF) mdl_r = 1;
      if (lv && le && !lw && lo && la == 12'hFFE) mdl_l = 0;
      if (rv && re && rw && ra == 12'hFFE) mdl_l = 1;
    end
    #5;
  endtask

  task automatic idle(); drive(0,0,0,0,0, 0,0,0,0,0); endtask

  task automatic expect2(string req, bit el, bit er);
    chk(req, l_irq_n, ~el); chk(req, r_irq_n, ~er);
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(negedge clk) if (rst_n) begin
    chk("R9 model", l_irq_n, ~mdl_l);
    chk("R9 model", r_irq_n, ~mdl_r);
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    expect2("R1", 0, 0);
    rst_n = 1;
    drive(1,1,1,0,12'hFFF, 0,0,0,0,0);      expect2("R2", 0, 1);
    drive(0,0,0,0,0, 1,1,0,0,12'hFFF);      expect2("R6 oe low", 0, 1);
    drive(0,0,0,0,0, 0,1,0,1,12'hFFF);      expect2("R6 vld low", 0, 1);
    drive(0,0,0,0,0, 1,0,0,1,12'hFFF);      expect2("R6 en low", 0, 1);
    drive(0,0,0,0,0, 1,1,0,1,12'hFFE);      expect2("R8 other box", 0, 1);
    drive(0,0,0,0,0, 1,1,0,1,12'hFFF);      expect2("R3", 0, 0);
    drive(0,0,0,0,0, 1,1,1,0,12'hFFE);      expect2("R4", 1, 0);
    drive(1,1,0,1,12'hFFF, 1,1,1,0,12'hFFF); expect2("R8 own box", 1, 0);
    drive(1,0,1,0,12'hFFF, 0,0,0,0,0);      expect2("R6 write en low", 1, 0);
    drive(1,1,1,0,12'h123, 0,0,0,0,0);      expect2("R8 other addr", 1, 0);
    idle();                                 expect2("R9", 1, 0);
    drive(1,1,0,1,12'hFFE, 0,0,0,0,0);      expect2("R5", 0, 0);
    drive(1,1,1,0,12'hFFF, 1,1,0,1,12'hFFF); expect2("R7 right", 0, 1);
    drive(1,1,0,1,12'hFFE, 1,1,1,0,12'hFFE); expect2("R7 left", 1, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] la, ra;
      la = ($urandom_range(0,3) == 0) ? 12'(12'hFFE + $urandom_range(0,1)) : 12'($urandom);
      ra = ($urandom_range(0,3) == 0) ? 12'(12'hFFE + $urandom_range(0,1)) : 12'($urandom);
      drive($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), la,
            $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), ra);
    end
    rst_n = 0;
    idle();
    expect2("R1 re-reset", 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule